// File: doc/BRIEF.md
# Double-Buffered Serial Slave Transmitter

This block sends data words out of a chip over a 3-wire synchronous serial link, with the chip acting as the slave. An external master supplies the serial clock. The host places a word in a holding register. The block moves that word into a shift register and drives it out most significant bit first, one bit per master clock period. While one frame is being shifted out, the holding register is free again, so the host can queue the next word. If a word is waiting when a frame finishes, the next frame follows with no idle clock period in between.

The master samples on the rising edge of the serial clock. The block presents the first bit of a frame before the first rising edge and changes the data line only after falling edges. The serial clock is brought into the system clock domain through a synchronizer, so the system clock must run at least four times faster than the serial clock. The block raises a one-cycle interrupt each time the holding register is emptied into the shifter. A busy flag stays high from the host write until a frame ends with nothing queued. Frame length is selectable from 8 to 16 bits. Receive capture is not part of this block, so it never raises a receive-complete event.

Top module: `stx_spi_slave_tx`

## Requirements
- R1: A host write (hold_wr high for one cycle while both pwr_on and xmit_en are high) sets busy to 1 on the next clock edge. Busy then stays high while the block waits for serial clock edges.
- R2: A frame is driven on sdout most significant bit first. The first bit is valid before the first rising edge of sclk, and each later bit appears after a falling edge of sclk.
- R3: When the holding register contents are copied into the shift register, txe_irq is high for exactly one system clock cycle. During that cycle the holding register is empty.
- R4: If a word is waiting in the holding register when the last bit of a frame has been sampled, that word's first bit replaces it after the next falling edge. No extra serial clock period is inserted between the two frames.
- R5: If no word is waiting when a frame ends, busy returns to 0 after the falling edge that follows the last sampling edge, and sdout returns to 0.
- R6: The frame length in bits is 8 + len_sel for len_sel values 0 to 8. Any len_sel value above 8 gives 16 bits. The length is captured when a word enters the shifter.
- R7: A host write while the holding register is full is ignored, and overrun becomes 1. Overrun stays 1 until the block is disabled.
- R8: While pwr_on or xmit_en is 0, the block is idle: busy, sdout, txe_irq and overrun are 0, the holding register is emptied, and host writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_on | input | 1 | Block power enable |
| xmit_en | input | 1 | Transmit enable |
| hold_wr | input | 1 | One-cycle host write strobe for the holding register |
| hold_wdata | input | 16 | Word to transmit, right-aligned |
| len_sel | input | 4 | Frame length code |
| sclk | input | 1 | Serial clock from the external master, asynchronous |
| sdout | output | 1 | Serial data output |
| busy | output | 1 | Transmission in progress or word queued |
| txe_irq | output | 1 | Holding register emptied pulse |
| overrun | output | 1 | Sticky flag for a write that was ignored |

## Verification
The bench drives back-to-back frames and checks that the second word's most significant bit is sampled on the rising edge right after the first word's last bit. A design that inserted a gap, or that dropped busy between the frames, would shift the second word by one bit or emit an idle bit. It writes three words in a row so the third lands on a full holding register: a design without overrun protection would corrupt the queued word, and the received frames would then show it. It sweeps the length code across 12, 16 and saturated values, where a decoder that wraps would send short frames. It also disables the block in mid-frame and re-enables it, checking that no stale word or stale overrun survives.

// File: rtl/stx_pkg.sv
// Shared constants and types for the serial slave transmitter.
package stx_pkg;
    localparam int STX_MAX_BITS = 16;
    localparam int STX_MIN_BITS = 8;
    localparam int STX_CODE_W   = 4;
    localparam int STX_SYNC     = 2;

    // Shifter occupancy: idle, or a frame is being sent
    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_t;
endpackage

// File: rtl/stx_sclk_sync.sv
// Brings the asynchronous serial clock into the system domain and flags its
// edges. Assumes the system clock is at least 4x the serial clock, so that
// each serial clock level is seen for at least two system cycles.
module stx_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_async,
    output logic rise,
    output logic fall
);
    localparam int TOP = STAGES;

    logic [TOP:0] pipe;

    // Synchronizer chain plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[TOP-1:0], sclk_async};
    end

    // Edge flags from the last synchronized stage and its history
    always_comb begin
        rise = pipe[TOP-1] & ~pipe[TOP];
        fall = ~pipe[TOP-1] & pipe[TOP];
    end
endmodule

// File: rtl/stx_hold_buf.sv
// Transmit holding register. It accepts one host word when empty and flags
// a write to a full register as an overrun. It is emptied by the shifter's
// take strobe. Disabling the block empties it and clears the overrun.
module stx_hold_buf #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data,
    output logic          ovr
);
    // Holding register fill, drain and overrun tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            ovr  <= 1'b0;
        end else if (!enable) begin
            full <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            if (take) full <= 1'b0;
            if (wr) begin
                if (full) begin
                    ovr <= 1'b1;
                end else begin
                    full <= 1'b1;
                    data <= wdata;
                end
            end
        end
    end

    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ovr) |=> ovr);
    assert_full_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wr && full) |=> $stable(data));
    assert_disabled_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!full && !ovr));
endmodule

// File: rtl/stx_shifter.sv
// Frame shifter. It loads a word from the holding register when idle, or
// right at a frame boundary, and left-aligns it for the chosen length. It
// counts sampling (rising) edges and advances the data line on falling
// edges. The frame ends on the falling edge after the last sample.
// Assumes the master idles the clock low.
module stx_shifter
    import stx_pkg::*;
#(
    parameter int MAX_BITS = 16,
    parameter int MIN_BITS = 8,
    parameter int CODE_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                rise,
    input  logic                fall,
    input  logic                hold_full,
    input  logic [MAX_BITS-1:0] hold_data,
    input  logic [CODE_W-1:0]   len_code,
    output logic                take,
    output logic                irq,
    output logic                active,
    output logic                sdo
);
    localparam int LEN_W = $clog2(MAX_BITS + 1);
    localparam int SPAN  = MAX_BITS - MIN_BITS;

    sh_state_t            st;
    logic [MAX_BITS-1:0]  sh;
    logic [LEN_W-1:0]     cnt;
    logic [LEN_W-1:0]     flen;
    logic [LEN_W-1:0]     new_len;
    logic [LEN_W-1:0]     shamt;
    logic                 at_end;

    // Length code decode with saturation at the maximum frame size
    always_comb begin
        if (int'(len_code) > SPAN) new_len = LEN_W'(MAX_BITS);
        else                       new_len = LEN_W'(MIN_BITS) + LEN_W'(len_code);
        shamt = LEN_W'(MAX_BITS) - new_len;
    end

    // Handoff decision: load when idle, or at the closing falling edge
    always_comb begin
        at_end = fall && (cnt == flen);
        take   = enable && hold_full && (st == SH_IDLE || at_end);
    end

    // Frame sequencing, bit counting and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= SH_IDLE;
            sh   <= '0;
            cnt  <= '0;
            flen <= LEN_W'(MIN_BITS);
            irq  <= 1'b0;
        end else if (!enable) begin
            st  <= SH_IDLE;
            sh  <= '0;
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= take;
            if (take) begin
                sh   <= hold_data << shamt;
                flen <= new_len;
                cnt  <= '0;
                st   <= SH_RUN;
            end else if (st == SH_RUN) begin
                if (rise && cnt < flen) begin
                    cnt <= cnt + LEN_W'(1);
                end else if (fall && cnt != '0) begin
                    if (cnt == flen) st <= SH_IDLE;
                    else             sh <= sh << 1;
                end
            end
        end
    end

    // Output stage
    always_comb begin
        active = (st == SH_RUN);
        sdo    = active & sh[MAX_BITS-1];
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= flen);
    assert_len_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (int'(flen) >= MIN_BITS && int'(flen) <= MAX_BITS));
endmodule

// File: rtl/stx_spi_slave_tx.sv
// Double-buffered slave-mode serial transmitter. The host writes words into
// a holding register. The shifter sends them MSB first under an external
// serial clock, with back-to-back frames when a word is queued in time.
// Assumes the master samples on rising edges and clk >= 4x sclk.
module stx_spi_slave_tx
    import stx_pkg::*;
#(
    parameter int MAX_BITS    = STX_MAX_BITS,
    parameter int MIN_BITS    = STX_MIN_BITS,
    parameter int CODE_W      = STX_CODE_W,
    parameter int SYNC_STAGES = STX_SYNC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_on,
    input  logic                xmit_en,
    input  logic                hold_wr,
    input  logic [MAX_BITS-1:0] hold_wdata,
    input  logic [CODE_W-1:0]   len_sel,
    input  logic                sclk,
    output logic                sdout,
    output logic                busy,
    output logic                txe_irq,
    output logic                overrun
);
    logic                enable;
    logic                s_rise, s_fall;
    logic                hold_full, take, active;
    logic [MAX_BITS-1:0] hold_data;

    // Block is live only with both control bits set
    always_comb enable = pwr_on & xmit_en;

    stx_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_async(sclk),
        .rise(s_rise), .fall(s_fall)
    );

    stx_hold_buf #(.DW(MAX_BITS)) u_hold (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr(hold_wr),
        .wdata(hold_wdata), .take(take), .full(hold_full),
        .data(hold_data), .ovr(overrun)
    );

    stx_shifter #(.MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .CODE_W(CODE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rise(s_rise), .fall(s_fall),
        .hold_full(hold_full), .hold_data(hold_data), .len_code(len_sel),
        .take(take), .irq(txe_irq), .active(active), .sdo(sdout)
    );

    // Busy covers a frame in flight and a queued word
    always_comb busy = active | hold_full;

    assert_busy_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && hold_wr) |=> busy);
    assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        txe_irq |=> !txe_irq);
    assert_irq_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        txe_irq |-> !hold_full);
    assert_idle_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sdout);
    assert_off_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !overrun && !txe_irq));
endmodule

// File: tb/tb_stx_spi_slave_tx.sv
module tb_stx_spi_slave_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_on = 1'b0, xmit_en = 1'b0, hold_wr = 1'b0, sclk = 1'b0;
    logic [15:0] hold_wdata = '0;
    logic [3:0]  len_sel = '0;
    logic        sdout, busy, txe_irq, overrun;

    int checks = 0, errors = 0, irq_cnt = 0, cyc = 0;
    bit done = 0;
    bit rxq[$];

    always #5 clk = ~clk;

    stx_spi_slave_tx dut (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .xmit_en(xmit_en),
        .hold_wr(hold_wr), .hold_wdata(hold_wdata), .len_sel(len_sel),
        .sclk(sclk), .sdout(sdout), .busy(busy), .txe_irq(txe_irq),
        .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, updated on each rising clock edge
    int  h1 = 0, h2 = 0, h3 = 0;
    int  m_full = 0, m_hold = 0, m_ovr = 0, m_irq = 0;
    int  m_act = 0, m_word = 0, m_len = 8, m_cnt = 0, m_sh = 0;

    function automatic int len_of(input int code);
        return (code > 8) ? 16 : 8 + code;
    endfunction

    always @(posedge clk) begin
        int rs, fl, en, tk;
        rs = (h2 == 1 && h3 == 0);
        fl = (h2 == 0 && h3 == 1);
        h3 = h2; h2 = h1; h1 = int'(sclk);
        if (!rst_n) begin
            h1 = 0; h2 = 0; h3 = 0;
            m_full = 0; m_ovr = 0; m_irq = 0; m_act = 0; m_cnt = 0; m_sh = 0;
        end else begin
            en = pwr_on && xmit_en;
            tk = en && m_full && (!m_act || (fl && m_cnt == m_len));
            if (!en) begin
                m_full = 0; m_ovr = 0; m_irq = 0; m_act = 0; m_cnt = 0;
            end else begin
                m_irq = tk;
                if (tk) begin
                    m_word = m_hold; m_len = len_of(int'(len_sel));
                    m_cnt = 0; m_sh = 0; m_act = 1; m_full = 0;
                end else if (m_act) begin
                    if (rs && m_cnt < m_len) m_cnt++;
                    else if (fl && m_cnt > 0) begin
                        if (m_cnt == m_len) m_act = 0;
                        else m_sh++;
                    end
                end
                if (hold_wr) begin
                    if (m_full && !tk) m_ovr = 1;
                    else if (tk) m_ovr = 1;
                    else begin m_full = 1; m_hold = int'(hold_wdata); end
                end
            end
        end
    end

    // Compare every output with the model between clock edges
    always @(negedge clk) begin
        int e_sdo;
        if (rst_n && !done) begin
            e_sdo = m_act ? ((m_word >> (m_len - 1 - m_sh)) & 1) : 0;
            chk(int'(sdout) == e_sdo, "R2 sdout vs model", int'(sdout), e_sdo);
            chk(int'(busy) == (m_full || m_act), "R1 busy vs model", int'(busy), int'(m_full || m_act));
            chk(int'(txe_irq) == m_irq, "R3 txe_irq vs model", int'(txe_irq), m_irq);
            chk(int'(overrun) == m_ovr, "R7 overrun vs model", int'(overrun), m_ovr);
            if (txe_irq) irq_cnt++;
        end
    end

    // Master side: sample data on each rising serial clock edge
    always @(posedge sclk) rxq.push_back(sdout);

    task automatic write_word(input logic [15:0] d);
        @(negedge clk); hold_wr = 1'b1; hold_wdata = d;
        @(negedge clk); hold_wr = 1'b0;
    endtask

    task automatic clock_bits(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sclk = 1'b1; repeat (3) @(negedge clk);
            sclk = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic check_frame(input int exp, input int n, input string tag);
        int w = 0;
        if (rxq.size() < n) begin
            chk(0, tag, rxq.size(), n);
        end else begin
            for (int i = 0; i < n; i++) w = (w << 1) | int'(rxq.pop_front());
            chk(w == exp, tag, w, exp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && sdout == 0 && txe_irq == 0 && overrun == 0, "R8 reset idle", int'(busy), 0);
        pwr_on = 1; xmit_en = 1;
        repeat (2) @(negedge clk);

        // Single 8-bit frame
        n0 = irq_cnt;
        write_word(16'h00A5);
        chk(busy == 1, "R1 busy after write", int'(busy), 1);
        repeat (4) @(negedge clk);
        chk(irq_cnt - n0 == 1, "R3 one irq on handoff", irq_cnt - n0, 1);
        clock_bits(8);
        check_frame('hA5, 8, "R2 single frame MSB first");
        chk(busy == 0 && sdout == 0, "R5 busy clears at end", int'(busy), 0);

        // Back-to-back frames
        n0 = irq_cnt;
        write_word(16'h003C);
        repeat (4) @(negedge clk);
        write_word(16'h00C3);
        clock_bits(16);
        check_frame('h3C, 8, "R4 first of pair");
        check_frame('hC3, 8, "R4 second of pair no gap");
        chk(irq_cnt - n0 == 2, "R3 irq per handoff", irq_cnt - n0, 2);
        chk(busy == 0, "R5 idle after pair", int'(busy), 0);

        // Overrun
        write_word(16'h0011);
        repeat (4) @(negedge clk);
        write_word(16'h0022);
        write_word(16'h0033);
        chk(overrun == 1, "R7 overrun set", int'(overrun), 1);
        clock_bits(16);
        check_frame('h11, 8, "R7 first kept");
        check_frame('h22, 8, "R7 queued word intact");
        chk(overrun == 1 && busy == 0, "R7 overrun sticky", int'(overrun), 1);

        // Frame lengths
        len_sel = 4'd4;
        write_word(16'h0ABC);
        repeat (4) @(negedge clk);
        clock_bits(12);
        check_frame('hABC, 12, "R6 code 4 gives 12 bits");
        chk(busy == 0, "R6 12-bit frame ended", int'(busy), 0);
        len_sel = 4'd12;
        write_word(16'hBEEF);
        repeat (4) @(negedge clk);
        clock_bits(16);
        check_frame('hBEEF, 16, "R6 code 12 saturates to 16");
        len_sel = 4'd8;
        write_word(16'h8001);
        repeat (4) @(negedge clk);
        clock_bits(16);
        check_frame('h8001, 16, "R6 code 8 gives 16");
        len_sel = 4'd0;

        // Disable in mid-frame
        write_word(16'h005A);
        write_word(16'h0066);
        repeat (4) @(negedge clk);
        clock_bits(3);
        xmit_en = 0;
        repeat (2) @(negedge clk);
        chk(busy == 0 && sdout == 0 && overrun == 0, "R8 disable to idle", int'(busy), 0);
        write_word(16'h00FF);
        repeat (3) @(negedge clk);
        chk(busy == 0, "R8 write ignored while off", int'(busy), 0);
        rxq.delete();
        xmit_en = 1;
        repeat (3) @(negedge clk);
        chk(busy == 0, "R8 nothing queued after enable", int'(busy), 0);
        write_word(16'h0081);
        repeat (4) @(negedge clk);
        clock_bits(8);
        check_frame('h81, 8, "R8 fresh frame after re-enable");
        chk(rxq.size() == 0, "R5 no extra bits", rxq.size(), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule